// File: doc/BRIEF.md
# Transmit Byte Queue with Level-Selectable Interrupt and DMA Requests

This block sits between a host bus and the transmit serializer of a serial controller. The host pushes bytes with a single write strobe into a small queue. The serializer takes them out, oldest first, over a ready/valid handshake. The block drives three outputs from the queue fill level: a transmit-empty interrupt, a primary wait/request line and a secondary request line. All three are registered.

An 8-bit configuration register selects the fill level at which the interrupt and both requests are raised. With the whole-queue setting they wait until the queue holds nothing. With the entry-slot setting they are raised as soon as one slot is free. A second configuration bit sets how the secondary request is released. In one setting it is released a fixed four clocks after its condition ends. In the other it tracks the primary line exactly.

The secondary line is driven by a three-state machine: `SQ_IDLE`, `SQ_ACTIVE` and `SQ_HOLD`. Its transitions are:
- *raise*: `SQ_IDLE` to `SQ_ACTIVE`, when the primary request is about to assert.
- *release-follow*: `SQ_ACTIVE` to `SQ_IDLE`, in tracking mode.
- *release-delay*: `SQ_ACTIVE` to `SQ_HOLD`, in fixed-delay mode.
- *re-raise*: `SQ_HOLD` to `SQ_ACTIVE`.
- *expire*: `SQ_HOLD` to `SQ_IDLE`, when the hold count reaches zero.
- *disable*: any state to `SQ_IDLE`, when the secondary enable is low.

Top module: `txfifo_req`

## Requirements
- R1: While `rst_n` is low, the configuration reads 0x00, the queue is empty (`ser_valid`=0), `overrun`=0, and `txe_irq`, `wreq` and `sreq` are all 0.
- R2: Bytes are delivered on `ser_data` in the order they were accepted. A byte leaves the queue on each rising edge where `ser_valid` and `ser_ready` are both 1. `ser_valid` is 1 whenever at least one byte is stored.
- R3: The queue holds 4 bytes. A host write while 4 bytes are stored is dropped and sets `overrun`. `overrun` stays set until a cycle with `ovr_clr`=1.
- R4: With configuration bit 5 = 0, `txe_irq` is 1 after any edge that leaves fewer than 4 bytes stored, and 0 after any edge that leaves 4 bytes stored.
- R5: With configuration bit 5 = 1, `txe_irq` is 1 only after edges that leave the queue empty.
- R6: `wreq` equals `dma_mode` ANDed with the same level condition as `txe_irq`. It changes on the same edge as the write or pop that changes the fill level.
- R7: `sreq` is 0 after any edge where `sec_en` was 0, and stays 0 while `dma_mode` is 0.
- R8: With configuration bit 4 = 0, `sreq` asserts on the same edge as `wreq`. It stays asserted for exactly four more edges after the edge at which `wreq` deasserts.
- R9: With configuration bit 4 = 1, `sreq` equals `wreq` on every cycle while `sec_en` is 1.
- R10: Configuration bit 7 is reserved. It always reads 0, and writing it has no effect on any output.
- R11: A cycle with `chan_rst`=1 returns the block to the state of R1 at the next edge. This clears the configuration to 0x00, which selects entry-slot level and four-clock release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Configuration register contents |
| host_we | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host byte |
| ovr_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky dropped-write flag |
| dma_mode | input | 1 | Enables DMA-on-transmit requests |
| sec_en | input | 1 | Enables request mode on the secondary line |
| ser_ready | input | 1 | Serializer ready to take a byte |
| ser_valid | output | 1 | A byte is available |
| ser_data | output | 8 | Oldest stored byte |
| txe_irq | output | 1 | Transmit-empty interrupt |
| wreq | output | 1 | Primary wait/request |
| sreq | output | 1 | Secondary request |

## Verification
Configuration changes, host writes and pops all take effect at one rising edge. From that edge, `txe_irq`, `wreq` and `cfg_q` show the result with no further delay, and `sreq` asserts at the same edge. When `sreq` releases in fixed-delay mode, the bench counts the four edges after the one that drops `wreq` and expects `sreq` low only after the fourth. The bench drives inputs and checks outputs at falling edges, so each check sees exactly one rising edge after its stimulus. A scoreboard queue is filled by the host driver for each accepted byte and emptied by a monitor that compares `ser_data` on every handshake edge.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;
    localparam int CFG_W       = 8;
    localparam int CFG_LVL_BIT = 5;   // 1: whole queue empty, 0: entry slot free
    localparam int CFG_TIM_BIT = 4;   // 1: secondary tracks primary, 0: fixed delay
    localparam int CFG_RSV_BIT = 7;   // reserved, forced to zero

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ACTIVE = 2'd1,
        SQ_HOLD   = 2'd2
    } sreq_state_e;
endpackage

// File: rtl/txf_cfg.sv
module txf_cfg
    import txfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_nxt,
    output logic [CFG_W-1:0] cfg_q
);
    logic [CFG_W-1:0] wmask;

    generate
        for (genvar b = 0; b < CFG_W; b++) begin : g_mask
            if (b == CFG_RSV_BIT) begin : g_rsv
                assign wmask[b] = 1'b0;
            end else begin : g_keep
                assign wmask[b] = wdata[b];
            end
        end
    endgenerate

    always_comb begin
        if (clr)      cfg_nxt = '0;
        else if (we)  cfg_nxt = wmask;
        else          cfg_nxt = cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_nxt;
    end

    // R10: a write lands in the non-reserved bits, reserved bit reads zero
    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (cfg_q[6:0] == $past(wdata[6:0]) && !cfg_q[CFG_RSV_BIT]));
    // R11: channel reset clears the register
    p_cfg_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cfg_q == '0));
endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop_rdy,
    input  logic             ovr_clr,
    output logic             valid,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign valid   = (cnt != '0);
    assign rdata   = mem[rd_ptr];
    assign do_pop  = valid && pop_rdy;
    assign do_push = push && !full;

    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else
            unique case ({do_push, do_pop})
                2'b10:   cnt_nxt = cnt + 1'b1;
                2'b01:   cnt_nxt = cnt - 1'b1;
                default: cnt_nxt = cnt;
            endcase
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovr    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovr    <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (push && full) ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> ovr);
    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr && !clr) |=> ovr);
    p_pop_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && push && !clr) |=> (valid && rdata == $past(wdata)));
endmodule

// File: rtl/txf_sreq_fsm.sv
module txf_sreq_fsm
    import txfifo_pkg::*;
#(
    parameter int REL_CLKS = 4,
    localparam int HC_W = (REL_CLKS > 1) ? $clog2(REL_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic follow,
    input  logic req_nxt,
    output logic sreq
);
    localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(REL_CLKS - 1);

    sreq_state_e st, st_nxt;
    logic [HC_W-1:0] hcnt, hcnt_nxt;

    always_comb begin
        st_nxt   = st;
        hcnt_nxt = hcnt;
        if (!en) begin
            st_nxt = SQ_IDLE;                       // disable
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (req_nxt) st_nxt = SQ_ACTIVE; // raise
                end
                SQ_ACTIVE: begin
                    if (!req_nxt) begin
                        if (follow) begin
                            st_nxt = SQ_IDLE;        // release-follow
                        end else begin
                            st_nxt   = SQ_HOLD;      // release-delay
                            hcnt_nxt = HOLD_LOAD;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (req_nxt)
                        st_nxt = SQ_ACTIVE;          // re-raise
                    else if (follow || hcnt == '0)
                        st_nxt = SQ_IDLE;            // expire
                    else
                        hcnt_nxt = hcnt - 1'b1;
                end
                default: st_nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            hcnt <= '0;
        end else if (clr) begin
            st   <= SQ_IDLE;
            hcnt <= '0;
        end else begin
            st   <= st_nxt;
            hcnt <= hcnt_nxt;
        end
    end

    always_comb begin
        sreq = (st != SQ_IDLE);
    end

    p_sreq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !sreq);
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_HOLD && hcnt != '0 && en && !follow && !clr) |=> sreq);
endmodule

// File: rtl/txfifo_req.sv
module txfifo_req
    import txfifo_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 4,
    parameter int REL_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             host_we,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             ovr_clr,
    output logic             overrun,
    input  logic             dma_mode,
    input  logic             sec_en,
    input  logic             ser_ready,
    output logic             ser_valid,
    output logic [WIDTH-1:0] ser_data,
    output logic             txe_irq,
    output logic             wreq,
    output logic             sreq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CFG_W-1:0] cfg_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             lvl_nxt, wreq_nxt;

    txf_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chan_rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg_nxt (cfg_nxt),
        .cfg_q   (cfg_q)
    );

    txf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chan_rst),
        .push    (host_we),
        .wdata   (host_wdata),
        .pop_rdy (ser_ready),
        .ovr_clr (ovr_clr),
        .valid   (ser_valid),
        .rdata   (ser_data),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .ovr     (overrun)
    );

    always_comb begin
        if (cfg_nxt[CFG_LVL_BIT]) lvl_nxt = (cnt_nxt == '0);
        else                      lvl_nxt = (cnt_nxt < FULL_CNT);
        wreq_nxt = dma_mode && lvl_nxt && !chan_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_irq <= 1'b0;
            wreq    <= 1'b0;
        end else if (chan_rst) begin
            txe_irq <= 1'b0;
            wreq    <= 1'b0;
        end else begin
            txe_irq <= lvl_nxt;
            wreq    <= wreq_nxt;
        end
    end

    txf_sreq_fsm #(.REL_CLKS(REL_CLKS)) u_sfsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chan_rst),
        .en      (sec_en),
        .follow  (cfg_nxt[CFG_TIM_BIT]),
        .req_nxt (wreq_nxt),
        .sreq    (sreq)
    );

    p_full_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_irq && cfg_q[CFG_LVL_BIT]) |-> !ser_valid);
    p_wreq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wreq |-> $past(dma_mode));
    p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sreq && !wreq) |-> !cfg_q[CFG_TIM_BIT]);
    p_irq_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_CNT) |-> !txe_irq);
endmodule

// File: tb/sim_txfifo_req.sv
module sim_txfifo_req;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n, chan_rst, cfg_we, host_we, ovr_clr, dma_mode, sec_en, ser_ready;
    logic [7:0] cfg_wdata, host_wdata, cfg_q, ser_data;
    logic       overrun, ser_valid, txe_irq, wreq, sreq;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    bit done = 0;
    logic [7:0] sb[$];

    always #(CLK_P/2) clk = ~clk;

    txfifo_req u0 (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .host_we(host_we), .host_wdata(host_wdata),
        .ovr_clr(ovr_clr), .overrun(overrun),
        .dma_mode(dma_mode), .sec_en(sec_en),
        .ser_ready(ser_ready), .ser_valid(ser_valid), .ser_data(ser_data),
        .txe_irq(txe_irq), .wreq(wreq), .sreq(sreq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b);
        host_we    = 1'b1;
        host_wdata = b;
        if (mcount < 4) begin
            sb.push_back(b);
            mcount++;
        end
        step();
        host_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    // Scoreboard monitor: R2 ordering
    always @(posedge clk) begin
        if (rst_n && !chan_rst && ser_valid && ser_ready) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected byte actual=%0h expected=none", ser_data);
            end else begin
                chk("R2 order", ser_data, sb.pop_front());
                mcount--;
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chan_rst = 0; cfg_we = 0; cfg_wdata = 0; host_we = 0; host_wdata = 0;
        ovr_clr = 0; dma_mode = 1; sec_en = 1; ser_ready = 0;
        step(); step();
        // R1 reset state
        chk("R1 cfg", cfg_q, 8'h00);
        chk("R1 valid", ser_valid, 0);
        chk("R1 ovr", overrun, 0);
        chk("R1 irq", txe_irq, 0);
        chk("R1 wreq", wreq, 0);
        chk("R1 sreq", sreq, 0);
        rst_n = 1;
        step();
        chk("R4 irq empty", txe_irq, 1);
        chk("R6 wreq empty", wreq, 1);
        chk("R8 sreq with wreq", sreq, 1);

        // R4 entry-slot level, R8 fixed release
        host_write(8'h11); chk("R4 irq 1 byte", txe_irq, 1);
        host_write(8'h22); chk("R4 irq 2 bytes", txe_irq, 1);
        host_write(8'h33); chk("R4 irq 3 bytes", txe_irq, 1);
        host_write(8'h44);
        chk("R4 irq full", txe_irq, 0);
        chk("R6 wreq full", wreq, 0);
        chk("R8 sreq hold 0", sreq, 1);
        for (int i = 1; i < 4; i++) begin
            step();
            chk("R8 sreq hold", sreq, 1);
        end
        step();
        chk("R8 sreq released", sreq, 0);

        // R3 overrun
        host_write(8'hEE);
        chk("R3 ovr set", overrun, 1);
        step();
        chk("R3 ovr sticky", overrun, 1);
        ovr_clr = 1; step(); ovr_clr = 0;
        chk("R3 ovr cleared", overrun, 0);

        // R2 drain
        ser_ready = 1;
        step();
        chk("R4 irq after pop", txe_irq, 1);
        chk("R6 wreq after pop", wreq, 1);
        chk("R8 sreq after pop", sreq, 1);
        step(); step(); step();
        chk("R2 drained", ser_valid, 0);
        ser_ready = 0;

        // R5 whole-queue level
        cfg_write(8'h20);
        chk("R5 cfg", cfg_q, 8'h20);
        chk("R5 irq empty", txe_irq, 1);
        host_write(8'h55);
        chk("R5 irq 1 byte", txe_irq, 0);
        chk("R6 wreq 1 byte", wreq, 0);
        host_write(8'h66);
        ser_ready = 1;
        step();
        chk("R5 irq still 1", txe_irq, 0);
        step();
        chk("R5 irq empty again", txe_irq, 1);
        chk("R6 wreq empty again", wreq, 1);
        ser_ready = 0;

        // R9 tracking release
        cfg_write(8'h30);
        step(); step(); step(); step(); step();
        chk("R9 both up", {wreq, sreq}, 2'b11);
        host_write(8'h77);
        chk("R9 wreq down", wreq, 0);
        chk("R9 sreq down", sreq, 0);
        ser_ready = 1; step(); ser_ready = 0;
        chk("R9 wreq up", wreq, 1);
        chk("R9 sreq up", sreq, 1);

        // R10 reserved bit
        cfg_write(8'hA0);
        chk("R10 reads zero", cfg_q, 8'h20);
        host_write(8'h88);
        chk("R10 whole level", txe_irq, 0);
        cfg_write(8'h80);
        chk("R10 only rsv", cfg_q, 8'h00);
        chk("R10 no level effect", txe_irq, 1);
        ser_ready = 1; step(); ser_ready = 0;

        // R7 secondary disabled
        sec_en = 0; step();
        chk("R7 sreq off", sreq, 0);
        chk("R7 wreq on", wreq, 1);
        dma_mode = 0; sec_en = 1; step();
        chk("R7 sreq no dma", sreq, 0);
        chk("R6 wreq no dma", wreq, 0);
        dma_mode = 1;

        // R11 channel reset
        cfg_write(8'h30);
        host_write(8'h01); host_write(8'h02); host_write(8'h03); host_write(8'h04);
        host_write(8'h05);
        chk("R3 ovr again", overrun, 1);
        chan_rst = 1; step(); chan_rst = 0;
        sb.delete(); mcount = 0;
        chk("R11 cfg", cfg_q, 8'h00);
        chk("R11 valid", ser_valid, 0);
        chk("R11 ovr", overrun, 0);
        chk("R11 irq", txe_irq, 0);
        step();
        chk("R11 irq after", txe_irq, 1);
        chk("R11 wreq after", wreq, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule